// File: doc/BRIEF.md
# Rotating Five-Character Word Display Driver

This block drives a row of active-low seven-segment digits with a short word taken from a small alphabet. The word is loaded as five 3-bit character codes, and a 3-bit rotation input turns the word circularly across the row. Each digit position has its own five-way selector. The selector picks one of five candidate codes, and a character decoder then turns the code into segment levels. The decoder shows the letters H, E, L and O. Every other code shows a blank digit.

The parameter `NDIGIT` selects the row length. With five digits the row shows exactly the loaded word. With eight digits the word is padded on the left with three blank codes, and the eight-entry padded sequence is turned instead. The block is purely combinational. It has no clock and no reset, and its outputs follow the inputs directly.

Top module: `word_rotator`

## Requirements
- R1: Character code 3'b000 displays H, 3'b001 displays E, 3'b010 displays L and 3'b011 displays O. Every code from 3'b100 to 3'b111 displays a blank digit.
- R2: The segment outputs are active low, indexed 0 to 6 (0=a, 1=b, 2=c, 3=d, 4=e, 5=f, 6=g). The patterns over bits [0:6] are:
  - H = 1001000
  - E = 0110000
  - L = 1110001
  - O = 0000001
  - blank = 1111111
- R3: `word_i[14:12]` holds the first (leftmost) character and `word_i[2:0]` holds the fifth. Digit 0 of `seg_n_o` is the leftmost digit.
- R4: The rotation amount k is taken from `rot_i`. Values 0 to 3 give k equal to the value. Any value with bit 2 set gives k = 4.
- R5: With NDIGIT=5, digit d shows character (d+k) mod 5. For example, HELLO at k=1 shows ELLOH, and at k=4 shows OHELL.
- R6: With NDIGIT=8, the padded sequence is three blanks followed by the five characters. Digit d shows padded entry (d+k) mod 8, so at k=0 the word is right-aligned behind three blanks.
- R7: Rotation values 5, 6 and 7 produce exactly the display of value 4.
- R8: The output depends only on the current inputs, with no storage. A changed input is visible without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| word_i | input | 15 | Five 3-bit character codes, first character in the top field |
| rot_i | input | 3 | Rotation amount select |
| seg_n_o | output | NDIGIT x 7 | Active-low segments per digit, digit 0 leftmost, bits [0:6] |

## Verification
Every rotation value, including the three aliases of value 4, is swept against several loaded words:
- HELLO, whose repeated L exposes a digit that takes the wrong neighbour.
- A word of five distinct characters (four letters and one blank), which tells every rotation step apart.
- Words with the blank codes 100 to 111 mixed into letter positions, which show whether the decoder ignores the two low code bits once bit 2 is set.

Both the five-digit and the eight-digit variants are exercised. In the eight-digit variant the blank padding moves into view and wraps around, which catches a wrong modulus or a wrong padding side.

// File: rtl/word_rotator_pkg.sv
package word_rotator_pkg;
  localparam int CODE_W  = 3;
  localparam int NCHAR   = 5;
  localparam int SEG_W   = 7;
  localparam logic [CODE_W-1:0] CODE_H     = 3'b000;
  localparam logic [CODE_W-1:0] CODE_E     = 3'b001;
  localparam logic [CODE_W-1:0] CODE_L     = 3'b010;
  localparam logic [CODE_W-1:0] CODE_O     = 3'b011;
  localparam logic [CODE_W-1:0] CODE_BLANK = 3'b100;
  typedef logic [CODE_W-1:0] code_t;
  typedef logic [0:SEG_W-1]  seg_t;
endpackage

// File: rtl/five_way_sel.sv
// Five-input selector built from four 2:1 stages, one slice per bit.
module five_way_sel #(
  parameter int W = 3
) (
  input  logic [W-1:0] in0,
  input  logic [W-1:0] in1,
  input  logic [W-1:0] in2,
  input  logic [W-1:0] in3,
  input  logic [W-1:0] in4,
  input  logic [2:0]   sel,
  output logic [W-1:0] out
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic pair_lo, pair_hi, quad;
    always_comb begin
      pair_lo = sel[0] ? in1[b] : in0[b];
      pair_hi = sel[0] ? in3[b] : in2[b];
      quad    = sel[1] ? pair_hi : pair_lo;
      out[b]  = sel[2] ? in4[b] : quad;
    end
  end
endmodule

// File: rtl/char_seg_dec.sv
// Reduced-alphabet decoder, active-low segments, Boolean form.
module char_seg_dec
  import word_rotator_pkg::*;
(
  input  code_t code,
  output seg_t  seg_n
);
  logic c2, c1, c0;
  always_comb begin
    {c2, c1, c0} = code;
    seg_n[0] = c2 | ~c0;
    seg_n[1] = c2 | (c1 ^ c0);
    seg_n[2] = c2 | (c1 ^ c0);
    seg_n[3] = c2 | (~c1 & ~c0);
    seg_n[4] = c2;
    seg_n[5] = c2;
    seg_n[6] = c2 | c1;
  end
endmodule

// File: rtl/word_rotator.sv
module word_rotator
  import word_rotator_pkg::*;
#(
  parameter int NDIGIT = 5
) (
  input  logic [NCHAR*CODE_W-1:0]  word_i,
  input  logic [2:0]               rot_i,
  output logic [NDIGIT-1:0][0:6]   seg_n_o
);
  localparam int PAD = NDIGIT - NCHAR;

  code_t padded [NDIGIT];

  for (genvar p = 0; p < NDIGIT; p++) begin : g_pad
    if (p < PAD) begin : g_blank
      assign padded[p] = CODE_BLANK;
    end else begin : g_char
      assign padded[p] = word_i[(NCHAR-1-(p-PAD))*CODE_W +: CODE_W];
    end
  end

  for (genvar d = 0; d < NDIGIT; d++) begin : g_digit
    code_t pick;
    seg_t  seg;
    five_way_sel #(.W(CODE_W)) u_sel (
      .in0 (padded[(d+0) % NDIGIT]),
      .in1 (padded[(d+1) % NDIGIT]),
      .in2 (padded[(d+2) % NDIGIT]),
      .in3 (padded[(d+3) % NDIGIT]),
      .in4 (padded[(d+4) % NDIGIT]),
      .sel (rot_i),
      .out (pick)
    );
    char_seg_dec u_dec (
      .code  (pick),
      .seg_n (seg)
    );
    assign seg_n_o[d] = seg;
  end
endmodule

// File: rtl/word_rotator_chk.sv
module word_rotator_chk
  import word_rotator_pkg::*;
#(
  parameter int NDIGIT = 5
) (
  input logic [NCHAR*CODE_W-1:0] word_i,
  input logic [2:0]              rot_i,
  input logic [NDIGIT-1:0][0:6]  seg_n_o
);
  localparam int PAD = NDIGIT - NCHAR;

  function automatic seg_t legal_pat(input code_t c);
    case (c)
      3'b000:  legal_pat = 7'b1001000;
      3'b001:  legal_pat = 7'b0110000;
      3'b010:  legal_pat = 7'b1110001;
      3'b011:  legal_pat = 7'b0000001;
      default: legal_pat = 7'b1111111;
    endcase
  endfunction

  always_comb begin
    for (int d = 0; d < NDIGIT; d++) begin
      // R2
      legal_pattern_chk: assert (seg_n_o[d] == legal_pat(3'b000) || seg_n_o[d] == legal_pat(3'b001) ||
                                 seg_n_o[d] == legal_pat(3'b010) || seg_n_o[d] == legal_pat(3'b011) ||
                                 seg_n_o[d] == 7'b1111111);
    end
    if (rot_i == 3'b000) begin
      for (int d = 0; d < NDIGIT; d++) begin
        if (d < PAD) begin
          // R6
          blank_pad_chk: assert (seg_n_o[d] == 7'b1111111);
        end else begin
          // R3
          field_order_chk: assert (seg_n_o[d] ==
            legal_pat(word_i[(NCHAR-1-(d-PAD))*CODE_W +: CODE_W]));
        end
      end
    end
    if (rot_i[2]) begin
      // R7
      top_bit_alias_chk: assert (seg_n_o[0] ==
        ((4 < PAD) ? 7'b1111111 : legal_pat(word_i[(NCHAR-1-(4-PAD))*CODE_W +: CODE_W])));
    end
  end
endmodule

bind word_rotator word_rotator_chk #(.NDIGIT(NDIGIT)) u_chk (
  .word_i  (word_i),
  .rot_i   (rot_i),
  .seg_n_o (seg_n_o)
);

// File: tb/tb_word_rotator.sv
module tb_word_rotator;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [14:0]    word;
  logic [2:0]     rot;
  logic [4:0][0:6] seg5;
  logic [7:0][0:6] seg8;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  word_rotator #(.NDIGIT(5)) dut  (.word_i(word), .rot_i(rot), .seg_n_o(seg5));
  word_rotator #(.NDIGIT(8)) dut8 (.word_i(word), .rot_i(rot), .seg_n_o(seg8));

  function automatic logic [0:6] exp_seg(input logic [2:0] c);
    logic [0:6] s;
    if (c[2]) s = 7'b1111111;
    else case (c[1:0])
      2'd0: s = 7'b1001000;
      2'd1: s = 7'b0110000;
      2'd2: s = 7'b1110001;
      default: s = 7'b0000001;
    endcase
    return s;
  endfunction

  function automatic logic [2:0] exp_code(input logic [14:0] w, input int n,
                                          input int d, input int r);
    int k, p, pad;
    k   = (r >= 4) ? 4 : r;
    pad = n - 5;
    p   = (d + k) % n;
    if (p < pad) return 3'b100;
    return w[(4-(p-pad))*3 +: 3];
  endfunction

  task automatic check_all(input string tag);
    for (int d = 0; d < 5; d++) begin
      logic [0:6] e;
      e = exp_seg(exp_code(word, 5, d, rot));
      checks++;
      if (seg5[d] !== e) begin
        fails++;
        $display("FAIL %s five-digit w=%b rot=%0d digit %0d got %b exp %b", tag, word, rot, d, seg5[d], e);
      end
    end
    for (int d = 0; d < 8; d++) begin
      logic [0:6] e;
      e = exp_seg(exp_code(word, 8, d, rot));
      checks++;
      if (seg8[d] !== e) begin
        fails++;
        $display("FAIL %s eight-digit w=%b rot=%0d digit %0d got %b exp %b", tag, word, rot, d, seg8[d], e);
      end
    end
  endtask

  // H=000 E=001 L=010 O=011
  localparam logic [14:0] HELLO = {3'b000, 3'b001, 3'b010, 3'b010, 3'b011};

  initial begin
    logic [14:0] words [6];
    words[0] = HELLO;
    words[1] = {3'b011, 3'b010, 3'b001, 3'b000, 3'b100};
    words[2] = {3'b101, 3'b000, 3'b110, 3'b011, 3'b111};
    words[3] = {3'b100, 3'b101, 3'b110, 3'b111, 3'b001};
    words[4] = 15'h0000;
    words[5] = {3'b010, 3'b111, 3'b011, 3'b100, 3'b000};

    word = 15'h0; rot = 3'b000;
    @(negedge clk);
    check_all("R1 R2 all-H idle");

    // R5 explicit: HELLO rotations on five digits
    word = HELLO; rot = 3'd1;
    @(negedge clk);
    check_all("R5 ELLOH");

    foreach (words[i]) begin
      for (int r = 0; r < 8; r++) begin
        word = words[i];
        rot  = 3'(r);
        @(negedge clk);
        if (r >= 5) check_all("R7 alias of 4");
        else if (i == 2 || i == 3) check_all("R1 blank codes R3 R4");
        else check_all("R4 R5 R6 rotation");
      end
    end

    // R8: change without waiting for a clock edge
    word = HELLO; rot = 3'd2;
    #3;
    check_all("R8 combinational");
    done = 1'b1;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired got running exp finished");
    end
  end

  initial begin
    wait (done);
    #1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule